// File: doc/BRIEF.md
# Serial Port Bit-Rate Tick Selector

This block turns a set of rate sources into the timing strobes for a four-mode serial port. From a one-cycle oscillator enable and the overflow pulses of two free-running timers, it produces a 16x-oversampling tick for the receiver and a separate one for the transmitter. In the synchronous shift mode it produces a shift-clock enable instead. The two directions may draw on different timers at the same time, so transmit and receive can run at unrelated rates.

The mode field selects the rate source. The shift mode divides the oscillator enable by a fixed twelve. The fixed-rate nine-bit mode divides the oscillator enable down to a bit rate of one sixty-fourth, or one thirty-second when the double-rate control bit is set. The two variable-rate modes take their ticks from timer overflows. For each direction, a select bit picks either the second timer, where every overflow is one tick, or the first timer. On the first-timer path, overflows pass through a divide-by-two stage that the double-rate bit bypasses. The timers, the shift registers and the register bus are outside the block.

Top module: `baud_tick_sel`

## Requirements
- R1: While rst_n is low, and in the first cycle after release, rx_tick16, tx_tick16 and shift_en are all 0. The internal divide counter and the first-timer stage start cleared.
- R2: In mode 0 (mode = 2'b00), shift_en is high for one cycle after every 12th accepted osc_en, and rx_tick16 and tx_tick16 stay 0. Each output goes high in the cycle after the clock edge that sampled the deciding input.
- R3: In mode 2 (mode = 2'b10) with ctrl_reg[7] = 0, rx_tick16 and tx_tick16 both pulse together once every 4 osc_en, which gives a bit period of 64 enables.
- R4: In mode 2 with ctrl_reg[7] = 1, both ticks pulse once every 2 osc_en, which gives a bit period of 32 enables.
- R5: In modes 1 and 3 (mode[0] = 1), a direction whose select bit is 1 (ctrl_reg[5] for receive, ctrl_reg[4] for transmit) ticks in the cycle after each t2_ovf pulse, and at no other time.
- R6: In modes 1 and 3, a direction whose select bit is 0 ticks on every second t1_ovf when ctrl_reg[7] = 0. The first-timer stage advances on every t1_ovf in every mode, and the first t1_ovf after reset does not give a tick.
- R7: In modes 1 and 3 with ctrl_reg[7] = 1, a direction whose select bit is 0 ticks on every t1_ovf.
- R8: The receive and transmit paths choose their sources independently. A pulse on the timer that one direction does not use never ticks that direction.
- R9: ctrl_reg[7] has no effect on the second-timer path or on the mode 0 rate.
- R10: ctrl_reg[6] and ctrl_reg[3:0] are reserved and have no effect on any output.
- R11: A change of the mode field clears the oscillator divide counter in that cycle. The first tick in the new mode therefore comes only after a full divide period of osc_en, never early. In modes 1 and 3 the oscillator path gives no tick, and in modes 0 and 2 timer overflows give no tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | One-cycle strobe per oscillator period |
| t1_ovf | input | 1 | First timer overflow pulse |
| t2_ovf | input | 1 | Second timer overflow pulse |
| mode | input | 2 | Serial mode: 0 shift, 1 timer 8-bit, 2 fixed 9-bit, 3 timer 9-bit |
| ctrl_reg | input | 8 | [7] double rate, [5] receive uses second timer, [4] transmit uses second timer, others reserved |
| rx_tick16 | output | 1 | Receiver 16x sampling tick |
| tx_tick16 | output | 1 | Transmitter 16x tick |
| shift_en | output | 1 | Mode 0 shift-clock enable |

## Verification
The bench builds the block with its default parameters: 16x oversampling, a divide of 12 for mode 0, a mode 2 base divide of 64, and a two-step first-timer stage. These small values let every mode reach many complete divide periods in a few hundred cycles. Short runs with random osc_en and sparse random overflows then cover the wrap of the mode 0 and mode 2 counters, and the odd and even phases of the first-timer stage. Mode switches part-way through a count, double-rate toggles and reserved-bit noise also fall within reach of these runs.

// File: rtl/bt_pkg.sv
package bt_pkg;

  typedef enum logic [1:0] {
    MODE_SHIFT = 2'd0,
    MODE_TMR8  = 2'd1,
    MODE_FIX9  = 2'd2,
    MODE_TMR9  = 2'd3
  } bt_mode_e;

  typedef struct packed {
    logic dbl;
    logic rx_t2;
    logic tx_t2;
  } bt_ctrl_t;

  function automatic bt_ctrl_t bt_decode(input logic dbl_bit, input logic rx_bit,
                                         input logic tx_bit);
    bt_ctrl_t c;
    c.dbl   = dbl_bit;
    c.rx_t2 = rx_bit;
    c.tx_t2 = tx_bit;
    return c;
  endfunction

endpackage

// File: rtl/bt_osc_div.sv
module bt_osc_div
  import bt_pkg::*;
#(
  parameter int M0_DIV  = 12,
  parameter int M2_TICK = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     osc_en,
  input  bt_mode_e mode,
  input  logic     dbl,
  output logic     fire_m0,
  output logic     fire_m2
);

  localparam int MAXDIV = (M0_DIV > M2_TICK) ? M0_DIV : M2_TICK;
  localparam int CNT_W  = (MAXDIV > 2) ? $clog2(MAXDIV) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last;
  bt_mode_e         mode_q;
  logic             fire;

  always_comb begin
    if (mode == MODE_SHIFT)
      last = CNT_W'(M0_DIV - 1);
    else if (dbl)
      last = CNT_W'(M2_TICK / 2 - 1);
    else
      last = CNT_W'(M2_TICK - 1);
  end

  always_comb begin
    cnt_d = cnt_q;
    fire  = 1'b0;
    if ((mode != mode_q) || mode[0]) begin
      cnt_d = '0;
    end else if (osc_en) begin
      if (cnt_q >= last) begin
        cnt_d = '0;
        fire  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  assign fire_m0 = fire && (mode == MODE_SHIFT);
  assign fire_m2 = fire && (mode == MODE_FIX9);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      mode_q <= MODE_SHIFT;
    end else begin
      cnt_q  <= cnt_d;
      mode_q <= mode;
    end
  end

endmodule

// File: rtl/bt_t1_stage.sv
module bt_t1_stage #(
  parameter int T1_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic t1_ovf,
  input  logic dbl,
  output logic t1_fire
);

  localparam int PW = (T1_DIV > 2) ? $clog2(T1_DIV) : 1;

  logic [PW-1:0] pre_q, pre_d;
  logic          at_end;

  assign at_end  = (pre_q == PW'(T1_DIV - 1));
  assign t1_fire = t1_ovf && (dbl || at_end);

  always_comb begin
    pre_d = pre_q;
    if (t1_ovf)
      pre_d = at_end ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

endmodule

// File: rtl/bt_dir_tick.sv
module bt_dir_tick
  import bt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  bt_mode_e mode,
  input  logic     use_t2,
  input  logic     t2_ovf,
  input  logic     t1_fire,
  input  logic     m2_fire,
  output logic     tick
);

  logic tick_d;

  always_comb begin
    if (mode[0]) tick_d = use_t2 ? t2_ovf : t1_fire;
    else         tick_d = m2_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick <= 1'b0;
    else        tick <= tick_d;
  end

endmodule

// File: rtl/baud_tick_sel.sv
module baud_tick_sel
  import bt_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int M0_DIV = 12,
  parameter int M2_DIV = 64,
  parameter int T1_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_en,
  input  logic       t1_ovf,
  input  logic       t2_ovf,
  input  logic [1:0] mode,
  input  logic [7:0] ctrl_reg,
  output logic       rx_tick16,
  output logic       tx_tick16,
  output logic       shift_en
);

  localparam int M2_TICK = M2_DIV / OVS;
  localparam int NDIR    = 2;

  bt_mode_e  mode_e;
  bt_ctrl_t  ctl;
  logic      fire_m0, fire_m2, t1_fire;
  logic      shift_d;
  logic      unused_rsvd;
  logic [NDIR-1:0] dir_sel;
  logic [NDIR-1:0] dir_tick;

  assign mode_e      = bt_mode_e'(mode);
  assign ctl         = bt_decode(ctrl_reg[7], ctrl_reg[5], ctrl_reg[4]);
  assign unused_rsvd = ^{ctrl_reg[6], ctrl_reg[3:0]};

  bt_osc_div #(.M0_DIV(M0_DIV), .M2_TICK(M2_TICK)) u_osc (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .mode(mode_e), .dbl(ctl.dbl),
    .fire_m0(fire_m0), .fire_m2(fire_m2)
  );

  bt_t1_stage #(.T1_DIV(T1_DIV)) u_t1 (
    .clk(clk), .rst_n(rst_n), .t1_ovf(t1_ovf), .dbl(ctl.dbl), .t1_fire(t1_fire)
  );

  // index 0 = receive, index 1 = transmit
  assign dir_sel = {ctl.tx_t2, ctl.rx_t2};

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    bt_dir_tick u_tick (
      .clk(clk), .rst_n(rst_n), .mode(mode_e), .use_t2(dir_sel[d]),
      .t2_ovf(t2_ovf), .t1_fire(t1_fire), .m2_fire(fire_m2), .tick(dir_tick[d])
    );
  end

  assign rx_tick16 = dir_tick[0];
  assign tx_tick16 = dir_tick[1];

  assign shift_d = fire_m0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_en <= 1'b0;
    else        shift_en <= shift_d;
  end

endmodule

// File: rtl/baud_tick_sel_chk.sv
module baud_tick_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       t1_ovf,
  input logic       t2_ovf,
  input logic [1:0] mode,
  input logic [7:0] ctrl_reg,
  input logic       rx_tick16,
  input logic       tx_tick16,
  input logic       shift_en
);

  // R2
  shift_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> (!rx_tick16 && !tx_tick16));

  // R2
  shift_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> ($past(mode) == 2'd0));

  // R2
  shift_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> !shift_en);

  // R3
  m2_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(mode[0])) |-> (rx_tick16 == tx_tick16));

  // R5
  tx_t2_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tick16 && $past(mode[0]) && $past(ctrl_reg[4])) |-> $past(t2_ovf));

  // R5
  rx_t2_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_tick16 && $past(mode[0]) && $past(ctrl_reg[5])) |-> $past(t2_ovf));

  // R6
  rx_t1_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_tick16 && $past(mode[0]) && !$past(ctrl_reg[5])) |-> $past(t1_ovf));

  // R6
  tx_t1_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tick16 && $past(mode[0]) && !$past(ctrl_reg[4])) |-> $past(t1_ovf));

endmodule

bind baud_tick_sel baud_tick_sel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .t1_ovf(t1_ovf), .t2_ovf(t2_ovf), .mode(mode),
  .ctrl_reg(ctrl_reg), .rx_tick16(rx_tick16), .tx_tick16(tx_tick16), .shift_en(shift_en)
);

// File: tb/baud_tick_sel_tb.sv
`timescale 1ns/1ps
module baud_tick_sel_tb;

  localparam int TB_M0  = 12;
  localparam int TB_M2T = 64 / 16;

  logic       clk;
  logic       rst_n;
  logic       osc_en, t1_ovf, t2_ovf;
  logic [1:0] mode;
  logic [7:0] ctrl_reg;
  logic       rx_tick16, tx_tick16, shift_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [2:0] exp_q[$];
  string      tag_q[$];

  int   m_cnt;
  int   m_pre;
  logic [1:0] m_mode;

  baud_tick_sel u_dut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .t1_ovf(t1_ovf), .t2_ovf(t2_ovf),
    .mode(mode), .ctrl_reg(ctrl_reg), .rx_tick16(rx_tick16), .tx_tick16(tx_tick16),
    .shift_en(shift_en)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  // expected outputs for the cycle after the next edge, from the requirements
  task automatic step(input string tag, input bit oe, input bit a1, input bit a2,
                      input logic [1:0] md, input bit dbl, input bit rxs, input bit txs,
                      input bit noise);
    logic [7:0] cr;
    int  last;
    bit  fire, t1f, rx, tx, sh;
    @(negedge clk);
    cr = {dbl, 1'b0, rxs, txs, 4'b0000};
    if (noise) begin
      cr[6]   = 1'($urandom_range(0, 1));
      cr[3:0] = 4'($urandom_range(0, 15));
    end
    osc_en = oe; t1_ovf = a1; t2_ovf = a2; mode = md; ctrl_reg = cr;
    last = (md == 2'd0) ? TB_M0 - 1 : (dbl ? TB_M2T / 2 - 1 : TB_M2T - 1);
    fire = 0;
    if (md != m_mode || md[0]) m_cnt = 0;
    else if (oe) begin
      if (m_cnt >= last) begin m_cnt = 0; fire = 1; end
      else m_cnt++;
    end
    m_mode = md;
    t1f = a1 && (dbl || m_pre == 1);
    if (a1) m_pre = (m_pre == 1) ? 0 : 1;
    sh = fire && md == 2'd0;
    if (md[0]) begin
      rx = rxs ? a2 : t1f;
      tx = txs ? a2 : t1f;
    end else begin
      rx = fire && md == 2'd2;
      tx = rx;
    end
    exp_q.push_back({rx, tx, sh});
    tag_q.push_back(tag);
  endtask

  task automatic run(input string tag, input int n, input logic [1:0] md, input bit dbl,
                     input bit rxs, input bit txs, input int osc_pct, input bit noise);
    for (int i = 0; i < n; i++)
      step(tag, ($urandom_range(1, 100) <= osc_pct), ($urandom_range(0, 3) == 0),
           ($urandom_range(0, 3) == 0), md, dbl, rxs, txs, noise);
  endtask

  // monitor
  initial begin
    logic [2:0] e;
    string t;
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({rx_tick16, tx_tick16, shift_en} !== e) begin
          fails++;
          $display("FAIL %s: {rx,tx,shift} actual %b expected %b at %0t", t,
                   {rx_tick16, tx_tick16, shift_en}, e, $time);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; osc_en = 0; t1_ovf = 0; t2_ovf = 0; mode = 2'd0; ctrl_reg = 8'h00;
    m_cnt = 0; m_pre = 0; m_mode = 2'd0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      osc_en = 1; t1_ovf = 1; t2_ovf = 1; mode = 2'd2;
      checks++;
      if ({rx_tick16, tx_tick16, shift_en} !== 3'b000) begin
        fails++;
        $display("FAIL R1: reset outputs actual %b expected 000",
                 {rx_tick16, tx_tick16, shift_en});
      end
    end
    @(negedge clk);
    osc_en = 0; t1_ovf = 0; t2_ovf = 0; mode = 2'd0;
    rst_n = 1;
    step("R1", 0, 0, 0, 2'd0, 0, 0, 0, 0);

    run("R2", 40, 2'd0, 0, 0, 0, 100, 0);
    run("R2", 60, 2'd0, 0, 1, 1, 40, 0);
    run("R9", 40, 2'd0, 1, 0, 0, 100, 0);
    run("R3", 40, 2'd2, 0, 0, 1, 100, 0);
    run("R3", 40, 2'd2, 0, 1, 0, 60, 0);
    run("R4", 40, 2'd2, 1, 0, 0, 100, 0);
    run("R5", 40, 2'd3, 0, 1, 1, 50, 0);
    run("R9", 40, 2'd1, 1, 1, 1, 50, 0);
    run("R6", 60, 2'd1, 0, 0, 0, 50, 0);
    run("R7", 40, 2'd3, 1, 0, 0, 50, 0);
    run("R8", 60, 2'd1, 0, 1, 0, 50, 0);
    run("R8", 60, 2'd3, 1, 0, 1, 50, 0);
    run("R10", 80, 2'd2, 0, 1, 0, 100, 1);
    run("R10", 80, 2'd0, 0, 0, 1, 100, 1);
    run("R10", 80, 2'd3, 0, 0, 1, 50, 1);
    for (int k = 0; k < 12; k++) begin
      run("R11", 7 + k, 2'(k % 4), 1'(k % 3 == 0), 1'(k % 2), 1'(k / 2 % 2), 100, 0);
      run("R11", 3, 2'(k % 4 ^ 2), 0, 0, 0, 100, 0);
    end
    step("R11", 0, 0, 0, 2'd0, 0, 0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule